// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple on-chip request port and a 256K x 16 asynchronous EDO DRAM that has a multiplexed 9-bit address bus. A host presents an 18-bit word address, a read/write flag, a two-bit byte enable and write data. It holds the request until a one-cycle acknowledge. The controller splits the address into a row half and a column half. It generates the RAS, the two byte CAS strobes, WE and OE, and drives the data bus with a separate tri-state enable. Read data comes back later with a one-cycle valid pulse.

The controller leaves a row open after an access. A later access to the same row therefore costs only a column cycle. An access to another row, a pending refresh, or an open-row age limit closes the page and precharges. Writes are always early writes, so the DRAM output never turns on during a write. Refresh is requested from outside. The controller closes the page first, grants the request, and then runs a CAS-before-RAS refresh cycle. Every timing is a parameter counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and right after it, ras_no, ucas_no, lcas_no, we_no and oe_no are 1. dq_oe_o, ack_o, rvalid_o and ref_gnt_o are 0.
- R2: Word address bits [17:9] are the row and bits [8:0] are the column. The row is on dram_a_o when RAS falls, and the column is on dram_a_o when CAS falls.
- R3: When a row is opened, dram_a_o holds the row for T_RAH cycles after RAS falls. The first CAS falls exactly T_RCD cycles after RAS falls.
- R4: An access to the open row starts no new RAS cycle. Each CAS stays low exactly T_CAS cycles and stays high at least T_CP cycles between column cycles.
- R5: An access to a different row closes the page. RAS stays low at least T_RAS_MIN cycles, and stays high at least T_RP cycles before it falls again.
- R6: For a write, WE is low, dq_oe_o is 1 and oe_no is 1 when CAS falls (early write).
- R7: be_i[1] selects ucas_no (dq bits 15:8) and be_i[0] selects lcas_no (dq bits 7:0). When both are selected they fall in the same cycle, and an unselected byte keeps its stored value.
- R8: For a read, rvalid_o is high for one cycle, T_CAC+1 clock edges after the edge on which CAS fell. In that cycle rdata_o holds the addressed word.
- R9: RAS never stays low longer than PAGE_MAX cycles. An idle open page is closed without any new request.
- R10: ref_gnt_o pulses only while RAS is high. The refresh that follows pulls both CAS strobes low before RAS falls, with WE high and the data bus not driven.
- R11: Every request gets exactly one single-cycle ack_o, and every acknowledged request makes exactly one column cycle.
- R12: dq_oe_o is never 1 while oe_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address, row in [17:9], column in [8:0] |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enable, [1] upper byte, [0] lower byte, nonzero |
| ack_o | output | 1 | One-cycle request acceptance |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | One-cycle read data valid |
| ref_req_i | input | 1 | Refresh request, held until ref_gnt_o |
| ref_gnt_o | output | 1 | One-cycle refresh grant |
| ras_no | output | 1 | Row strobe, active low |
| ucas_no | output | 1 | Upper byte column strobe, active low |
| lcas_no | output | 1 | Lower byte column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| oe_no | output | 1 | Output enable, active low |
| dram_a_o | output | 9 | Multiplexed row/column address |
| dq_o | output | 16 | Data driven to the DRAM |
| dq_oe_o | output | 1 | Drive enable for dq_o |
| dq_i | input | 16 | Data returned by the DRAM |

## Verification
Every DRAM pin is a register loaded on the same edge as the state it belongs to. The bench therefore samples at the falling clock edge and counts whole edges. The first CAS fall must come exactly T_RCD edges after the RAS fall. A CAS stays low for exactly T_CAS edges. rvalid_o must appear exactly T_CAC+1 edges after the read's CAS fall. The bench's DRAM model returns a poison word until T_CAC edges have passed, so a capture made too early is caught by the data comparison. Precharge, RAS width, open-page age and refresh ordering are measured as edge counts between pin transitions and compared with the parameter bounds.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_RCD, ST_COL, ST_CAS, ST_CP, ST_OPEN, ST_PRE, ST_RFC, ST_RFR
  } st_e;
endpackage

// File: rtl/edo_cnt.sv
module edo_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/edo_page.sv
module edo_page #(
  parameter int ROW_W   = 9,
  parameter int RAS_MIN = 15,
  parameter int LIMIT   = 248
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             close_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             min_ok_o,
  output logic             near_o
);
  localparam int SAT   = (LIMIT > RAS_MIN) ? LIMIT : RAS_MIN;
  localparam int AGE_W = $clog2(SAT + 1) + 1;

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
      age_q  <= '0;
    end else if (open_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
      age_q  <= '0;
    end else if (close_i) begin
      open_q <= 1'b0;
    end else if (open_q && age_q < AGE_W'(SAT)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign min_ok_o = age_q >= AGE_W'(RAS_MIN - 1);
  assign near_o   = open_q && (age_q >= AGE_W'(LIMIT));
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DW        = 16,
  parameter int T_RAH     = 3,
  parameter int T_RCD     = 5,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 3,
  parameter int T_CAC     = 4,
  parameter int T_RAS_MIN = 15,
  parameter int T_RP      = 10,
  parameter int PAGE_MAX  = 256
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [1:0]             be_i,
  output logic                   ack_o,
  output logic [DW-1:0]          rdata_o,
  output logic                   rvalid_o,
  input  logic                   ref_req_i,
  output logic                   ref_gnt_o,
  output logic                   ras_no,
  output logic                   ucas_no,
  output logic                   lcas_no,
  output logic                   we_no,
  output logic                   oe_no,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_a_o,
  output logic [DW-1:0]          dq_o,
  output logic                   dq_oe_o,
  input  logic [DW-1:0]          dq_i
);
  localparam int AW       = ROW_W + COL_W;
  localparam int AMW      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int COL_SPAN = 1 + T_CAS + T_CP;
  localparam int LIMIT    = PAGE_MAX - COL_SPAN - 1;
  localparam int TW       = $clog2(T_RP + T_RAS_MIN + T_RCD + 2);
  localparam int CW       = $clog2(T_CAC + 2) + 1;

  st_e state_q, state_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          acc, pg_set, pg_close, pg_open, pg_min_ok, pg_near, gnt_d;
  logic [ROW_W-1:0] pg_row;

  logic             op_we_q, op_we_n;
  logic [1:0]       op_be_q, op_be_n;
  logic [ROW_W-1:0] op_row_q, op_row_n;
  logic [COL_W-1:0] op_col_q, op_col_n;
  logic [DW-1:0]    op_wd_q, op_wd_n;
  logic [CW-1:0]    cap_q;
  logic             hit;

  edo_cnt #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  edo_page #(.ROW_W(ROW_W), .RAS_MIN(T_RAS_MIN), .LIMIT(LIMIT)) u_page (
    .clk_i, .rst_ni, .open_i(pg_set), .row_i(addr_i[AW-1:COL_W]), .close_i(pg_close),
    .open_o(pg_open), .row_o(pg_row), .min_ok_o(pg_min_ok), .near_o(pg_near)
  );

  assign hit = pg_open && (pg_row == addr_i[AW-1:COL_W]);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    acc      = 1'b0;
    pg_set   = 1'b0;
    pg_close = 1'b0;
    gnt_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_req_i) begin
          state_d = ST_RFC; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1); gnt_d = 1'b1;
        end else if (req_i) begin
          state_d = ST_ROW; tmr_load = 1'b1; tmr_val = TW'(T_RAH - 1);
          acc = 1'b1; pg_set = 1'b1;
        end
      end
      ST_ROW: if (tmr_zero) begin
        state_d = ST_RCD; tmr_load = 1'b1; tmr_val = TW'(T_RCD - T_RAH - 1);
      end
      ST_RCD, ST_COL: if (tmr_zero) begin
        state_d = ST_CAS; tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1);
      end
      ST_CAS: if (tmr_zero) begin
        state_d = ST_CP; tmr_load = 1'b1; tmr_val = TW'(T_CP - 1);
      end
      ST_CP: if (tmr_zero) state_d = ST_OPEN;
      ST_OPEN: begin
        // refresh, age limit and row miss all close the page, once tRAS is met
        if (ref_req_i || pg_near || (req_i && !hit)) begin
          if (pg_min_ok) begin
            state_d = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1); pg_close = 1'b1;
          end
        end else if (req_i) begin
          state_d = ST_COL; acc = 1'b1;
        end
      end
      ST_PRE: if (tmr_zero) state_d = ST_IDLE;
      ST_RFC: if (tmr_zero) begin
        state_d = ST_RFR; tmr_load = 1'b1; tmr_val = TW'(T_RAS_MIN - 1);
      end
      ST_RFR: if (tmr_zero) begin
        state_d = ST_PRE; tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_we_n  = acc ? we_i                  : op_we_q;
    op_be_n  = acc ? be_i                  : op_be_q;
    op_row_n = acc ? addr_i[AW-1:COL_W]    : op_row_q;
    op_col_n = acc ? addr_i[COL_W-1:0]     : op_col_q;
    op_wd_n  = acc ? wdata_i               : op_wd_q;
  end

  // pins are registered from the next state so they switch cleanly on one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_we_q   <= 1'b0;
      op_be_q   <= '0;
      op_row_q  <= '0;
      op_col_q  <= '0;
      op_wd_q   <= '0;
      ack_o     <= 1'b0;
      ref_gnt_o <= 1'b0;
      ras_no    <= 1'b1;
      ucas_no   <= 1'b1;
      lcas_no   <= 1'b1;
      we_no     <= 1'b1;
      oe_no     <= 1'b1;
      dram_a_o  <= '0;
      dq_o      <= '0;
      dq_oe_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      op_we_q   <= op_we_n;
      op_be_q   <= op_be_n;
      op_row_q  <= op_row_n;
      op_col_q  <= op_col_n;
      op_wd_q   <= op_wd_n;
      ack_o     <= acc;
      ref_gnt_o <= gnt_d;
      ras_no    <= !(state_d inside {ST_ROW, ST_RCD, ST_COL, ST_CAS, ST_CP, ST_OPEN, ST_RFR});
      ucas_no   <= !((state_d == ST_CAS && op_be_n[1]) || state_d inside {ST_RFC, ST_RFR});
      lcas_no   <= !((state_d == ST_CAS && op_be_n[0]) || state_d inside {ST_RFC, ST_RFR});
      we_no     <= !(op_we_n && state_d inside {ST_RCD, ST_COL, ST_CAS});
      dq_oe_o   <= op_we_n && state_d inside {ST_RCD, ST_COL, ST_CAS};
      oe_no     <= !(!op_we_n && state_d inside {ST_CAS, ST_CP, ST_OPEN});
      dram_a_o  <= (state_d == ST_ROW) ? AMW'(op_row_n) : AMW'(op_col_n);
      dq_o      <= op_wd_n;
    end
  end

  // read capture T_CAC+1 edges after CAS fell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q    <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      if (state_d == ST_CAS && state_q != ST_CAS && !op_we_n) cap_q <= CW'(T_CAC + 1);
      else if (cap_q != '0)                                   cap_q <= cap_q - 1'b1;
      rvalid_o <= (cap_q == CW'(1));
      if (cap_q == CW'(1)) rdata_o <= dq_i;
    end
  end

  assert_lanes_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ucas_no) && !lcas_no) |-> $fell(lcas_no));
  assert_lanes_lower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lcas_no) && !ucas_no) |-> $fell(ucas_no));
  assert_early_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($fell(ucas_no) || $fell(lcas_no)) && !we_no) |-> (dq_oe_o && oe_no));
  assert_no_contention_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);
  assert_gnt_closed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_gnt_o |-> ras_no);
  assert_ack_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
endmodule

// File: tb/edo_dram_ctrl_bench.sv
module edo_dram_ctrl_bench;
  localparam int T_RAH = 3, T_RCD = 5, T_CAS = 3, T_CP = 3, T_CAC = 4;
  localparam int T_RAS_MIN = 15, T_RP = 10, PAGE_MAX = 256;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        req_i = 0, we_i = 0, ref_req_i = 0;
  logic [17:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = 2'b11;
  logic        ack_o, rvalid_o, ref_gnt_o, ras_no, ucas_no, lcas_no, we_no, oe_no, dq_oe_o;
  logic [15:0] rdata_o, dq_o;
  logic [15:0] dq_model = 16'hDEAD;
  logic [8:0]  dram_a_o;

  edo_dram_ctrl u_edo_dram_ctrl (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .be_i, .ack_o, .rdata_o,
    .rvalid_o, .ref_req_i, .ref_gnt_o, .ras_no, .ucas_no, .lcas_no, .we_no, .oe_no,
    .dram_a_o, .dq_o, .dq_oe_o, .dq_i(dq_model)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [15:0] mem    [int];
  logic [15:0] shadow [int];
  logic [15:0] exp_q  [$];

  function automatic logic [15:0] mem_rd(int k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction
  function automatic logic [15:0] sh_rd(int k);
    return shadow.exists(k) ? shadow[k] : 16'h0000;
  endfunction
  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  // DRAM model plus pin-timing monitor, sampled at the falling clock edge
  bit prev_ras = 1, prev_u = 1, prev_l = 1, in_ref = 0, first_col = 0, have_rise = 0, rd_pend = 0;
  logic [8:0] row_lat = '0;
  logic [15:0] rd_word;
  int ras_fall_cyc, ras_rise_cyc, cas_fall_cyc, cas_rise_cyc, rd_ready, last_rd_cas;
  int ras_falls = 0, col_cycles = 0, ref_cycles = 0, acks = 0, reqs = 0, refs = 0;

  always @(negedge clk) if (rst_ni) begin
    bit fu, fl;
    int key;
    if (prev_ras && !ras_no) begin
      ras_falls++;
      if (have_rise) chk(cyc - ras_rise_cyc >= T_RP, "R5 precharge", cyc - ras_rise_cyc, T_RP);
      ras_fall_cyc = cyc;
      in_ref = !ucas_no && !lcas_no;
      if (in_ref) begin
        ref_cycles++;
        chk(!prev_u && !prev_l && we_no && !dq_oe_o, "R10 cbr order", {prev_u, prev_l, we_no}, 0);
      end else begin
        row_lat = dram_a_o;
        first_col = 1;
      end
    end
    if (!prev_ras && ras_no) begin
      chk(cyc - ras_fall_cyc >= T_RAS_MIN, "R5 ras width", cyc - ras_fall_cyc, T_RAS_MIN);
      chk(cyc - ras_fall_cyc <= PAGE_MAX, "R9 ras max", cyc - ras_fall_cyc, PAGE_MAX);
      ras_rise_cyc = cyc;
      have_rise = 1;
    end
    if (!ras_no && !in_ref && (cyc - ras_fall_cyc) < T_RAH)
      chk(dram_a_o == row_lat, "R3 row hold", dram_a_o, row_lat);
    fu = prev_u && !ucas_no;
    fl = prev_l && !lcas_no;
    if ((fu || fl) && !ras_no && !in_ref) begin
      col_cycles++;
      chk((ucas_no || fu) && (lcas_no || fl), "R7 lanes together", {fu, fl}, 3);
      chk(!(dq_oe_o && !oe_no), "R12 no contention", {dq_oe_o, oe_no}, 3);
      if (first_col) chk(cyc - ras_fall_cyc == T_RCD, "R3 rcd", cyc - ras_fall_cyc, T_RCD);
      else chk(cyc - cas_rise_cyc >= T_CP, "R4 cas precharge", cyc - cas_rise_cyc, T_CP);
      first_col = 0;
      cas_fall_cyc = cyc;
      key = int'({row_lat, dram_a_o});
      if (!we_no) begin
        chk(dq_oe_o && oe_no, "R6 early write", {dq_oe_o, oe_no}, 3);
        mem[key] = merge(mem_rd(key), dq_o, {fu, fl});
      end else begin
        rd_word = mem_rd(key);
        rd_ready = cyc + T_CAC;
        rd_pend = 1;
        dq_model = 16'hDEAD;
        last_rd_cas = cyc;
      end
    end
    if ((!prev_u || !prev_l) && ucas_no && lcas_no && !in_ref) begin
      chk(cyc - cas_fall_cyc == T_CAS, "R4 cas width", cyc - cas_fall_cyc, T_CAS);
      cas_rise_cyc = cyc;
    end
    if (rd_pend && cyc >= rd_ready) begin
      dq_model = rd_word;
      rd_pend = 0;
    end else if (ras_no && ucas_no && lcas_no && !rd_pend) begin
      dq_model = 16'hDEAD;
    end
    if (rvalid_o) begin
      logic [15:0] e;
      e = (exp_q.size() != 0) ? exp_q.pop_front() : 16'hBEEF;
      chk(cyc - last_rd_cas == T_CAC + 1, "R8 latency", cyc - last_rd_cas, T_CAC + 1);
      chk(rdata_o == e, "R2 R8 read data", rdata_o, e);
    end
    if (ack_o) acks++;
    prev_ras = ras_no;
    prev_u = ucas_no;
    prev_l = lcas_no;
  end

  task automatic access(bit we, logic [17:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    req_i = 1; we_i = we; addr_i = a; wdata_i = d; be_i = be;
    do @(negedge clk); while (!ack_o);
    req_i = 0;
    reqs++;
    if (we) shadow[int'(a)] = merge(sh_rd(int'(a)), d, be);
    else exp_q.push_back(sh_rd(int'(a)));
    @(posedge clk);
  endtask

  task automatic refresh();
    @(negedge clk);
    ref_req_i = 1;
    do @(negedge clk); while (!ref_gnt_o);
    chk(ras_no == 1'b1, "R10 grant with page closed", ras_no, 1);
    ref_req_i = 0;
    refs++;
    @(posedge clk);
  endtask

  initial begin
    int rf;
    int unsigned seed;
    logic [8:0] rows [4];
    seed = $urandom(32'd20240611);
    rows[0] = 9'd0; rows[1] = 9'd1; rows[2] = 9'd77; rows[3] = 9'd511;
    repeat (4) @(negedge clk);
    chk(ras_no && ucas_no && lcas_no && we_no && oe_no, "R1 strobes in reset",
        {ras_no, ucas_no, lcas_no, we_no, oe_no}, 5'h1f);
    chk(!dq_oe_o && !ack_o && !rvalid_o && !ref_gnt_o, "R1 outputs in reset",
        {dq_oe_o, ack_o, rvalid_o, ref_gnt_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(ras_no && ucas_no && lcas_no && !dq_oe_o, "R1 after reset", {ras_no, ucas_no, lcas_no}, 7);

    // basic write then read, R2
    access(1, {9'd5, 9'd3}, 16'h1234, 2'b11);
    access(0, {9'd5, 9'd3}, 16'h0, 2'b11);
    // page hit, R4
    rf = ras_falls;
    access(1, {9'd5, 9'd7}, 16'hCAFE, 2'b11);
    access(0, {9'd5, 9'd7}, 16'h0, 2'b11);
    repeat (2) @(posedge clk);
    chk(ras_falls == rf, "R4 page hit keeps row", ras_falls, rf);
    // page miss, R5
    access(0, {9'd9, 9'd1}, 16'h0, 2'b11);
    repeat (2) @(posedge clk);
    chk(ras_falls == rf + 1, "R5 page miss reopens", ras_falls, rf + 1);
    // byte lanes, R7
    access(1, {9'd9, 9'd1}, 16'hAAAA, 2'b11);
    access(1, {9'd9, 9'd1}, 16'h5555, 2'b01);
    access(1, {9'd9, 9'd1}, 16'h12FF, 2'b10);
    access(0, {9'd9, 9'd1}, 16'h0, 2'b11);
    repeat (12) @(posedge clk);
    chk(sh_rd(int'({9'd9, 9'd1})) == 16'h1255, "R7 byte merge model", sh_rd(int'({9'd9, 9'd1})), 16'h1255);
    // refresh with a page open, R10
    rf = ref_cycles;
    refresh();
    repeat (T_CP + T_RAS_MIN + T_RP + 4) @(posedge clk);
    chk(ref_cycles == rf + 1, "R10 refresh cycle run", ref_cycles, rf + 1);
    // idle page closes by itself, R9
    access(0, {9'd5, 9'd3}, 16'h0, 2'b11);
    repeat (PAGE_MAX + 2) @(posedge clk);
    @(negedge clk);
    chk(ras_no == 1'b1, "R9 idle page closed", ras_no, 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      logic [1:0] be;
      a = {rows[$urandom % 4], 6'd0, 3'($urandom % 8)};
      be = 2'($urandom % 3 + 1);
      if ($urandom % 12 == 0) refresh();
      else if ($urandom % 2 == 0) access(1, a, 16'($urandom), be);
      else access(0, a, 16'h0, 2'b11);
    end

    repeat (60) @(posedge clk);
    chk(acks == reqs, "R11 one ack per request", acks, reqs);
    chk(col_cycles == reqs, "R11 one column cycle per request", col_cycles, reqs);
    chk(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 0);
    chk(ref_cycles == refs, "R10 refresh count", ref_cycles, refs);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule